// File: doc/BRIEF.md
# Dual-Channel Cosine Tone Synthesizer

This block makes digital tones by direct digital synthesis. A small prescaler thins the input clock into advance pulses. On each pulse a shared phase accumulator adds a programmable frequency step. The top bits of the accumulator address a cosine lookup that returns unsigned 8-bit samples centred on mid-scale. The lookup stores one quarter of the wave and mirrors it for the other three.

Two output channels read that one sample stream. Each channel shifts the sample toward mid-scale, adds a wrapping offset, and applies one of four bit-inversion patterns. A per-channel source bit then picks either that result or a fixed software byte, and the choice is registered. Every setting is a plain input held by the surrounding logic, so a new value takes effect on the next clock edge. The output frequency is f_clk × step / (65536 × (div + 1)).

Top module: `cwg_dual`

## Requirements
- R1: While `rst_n` is low, `ch_out` is all zeros and the phase accumulator and prescaler count are cleared.
- R2: While `tone_en` is high, the 16-bit accumulator adds `freq_step` modulo 65536 once every `div_sel`+1 cycles, and holds its value in the cycles between.
- R3: With `div_sel` = 0 the accumulator advances on every clock edge.
- R4: A clock edge with `tone_en` low clears the accumulator and the prescaler count, so after re-enabling, the phase sequence starts again from phase 0.
- R5: For accumulator value A and p = A[15:8], the generated sample is floor(128 + 127·cos(2πp/256) + 0.5). It is 255 at p = 0, 128 at p = 64 and 1 at p = 128.
- R6: The scale code of channel i (`ch_scale[2i+1:2i]`), with value c from 0 to 3, turns sample x into 128 + floor((x − 128) / 2^c).
- R7: The offset byte of channel i (`ch_offset[8i+7:8i]`) is added to the scaled sample modulo 256.
- R8: The invert code of channel i (`ch_invert[2i+1:2i]`) acts on the sum: 0 leaves it unchanged, 1 flips all 8 bits, 2 flips only bit 7, and 3 flips bits 6..0.
- R9: When `ch_src_gen[i]` is 0, channel i outputs its static byte `ch_static[8i+7:8i]` whatever `tone_en` and the generator are doing.
- R10: `ch_out[8i+7:8i]` after a clock edge shows the channel's processing of the accumulator value held just before that edge (one register of latency).
- R11: When `div_sel` is lowered below the prescaler's current count, the accumulator advances at the very next edge and the new period then holds.
- R12: Both channels use the same accumulator phase, and each applies its own scale, offset, invert and source settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tone_en | input | 1 | Runs the generator; low clears the phase |
| div_sel | input | 3 | Prescaler setting; division by div_sel+1 |
| freq_step | input | 16 | Phase increment per advance |
| ch_src_gen | input | 2 | Per channel: 1 = generated wave, 0 = static byte |
| ch_scale | input | 4 | Per-channel scale code, 2 bits each |
| ch_offset | input | 16 | Per-channel offset byte |
| ch_invert | input | 4 | Per-channel invert code, 2 bits each |
| ch_static | input | 16 | Per-channel static output byte |
| ch_out | output | 16 | Per-channel registered output byte |

## Verification
The bench steps through prescaler settings from 0 to 7 and a step of 0xFFFF that wraps every cycle. A prescaler off by one, or an accumulator that fails to wrap, puts the sample stream out of phase with the model. Mirroring mistakes in the quarter-wave table show up at the quadrant seams p = 64, 128 and 192, where a wrong sign or index gives values that break the cosine's symmetry. Scale codes on negative half-waves catch a logical shift used in place of an arithmetic one, and offsets near 0xFF catch saturation used in place of wrapping. Directed cases lower the divider mid-count, where an equality compare would stall the phase for most of a wrap, and restart the generator, where a phase left uncleared would resume mid-wave.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

  localparam int SCALE_W = 2;
  localparam int INV_W   = 2;

  typedef enum logic [INV_W-1:0] {
    INV_NONE = 2'd0,
    INV_ALL  = 2'd1,
    INV_MSB  = 2'd2,
    INV_LOW  = 2'd3
  } inv_mode_e;

  // pi/2 in Q28 fixed point
  localparam longint HALF_PI_Q28 = 64'sd421657428;

  // Rounded amp*cos((pi/2)*j/qn), evaluated at elaboration time by an
  // integer Taylor series (eight terms, Q28).
  function automatic int quarter_amp(int j, int qn, int amp);
    longint one;
    longint x;
    longint x2;
    longint term;
    longint sum;
    one  = 64'sd1 <<< 28;
    x    = (HALF_PI_Q28 * longint'(j)) / longint'(qn);
    x2   = (x * x) >>> 28;
    term = one;
    sum  = one;
    for (int n = 1; n <= 8; n++) begin
      term = -(((term * x2) >>> 28) / longint'((2 * n - 1) * (2 * n)));
      sum  = sum + term;
    end
    return int'((sum * longint'(amp) + (one >>> 1)) >>> 28);
  endfunction

endpackage

// File: rtl/cwg_phase.sv
module cwg_phase #(
  parameter int ACC_W = 16,
  parameter int DIV_W = 3,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [ACC_W-1:0] step,
  output logic [IDX_W-1:0] phase_idx
);

  logic [DIV_W-1:0] pre_cnt;
  logic [ACC_W-1:0] acc;
  logic             adv_tick;

  // ">=" so that a divider lowered mid-count fires at once
  assign adv_tick = run && (pre_cnt >= div_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      acc     <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      acc     <= '0;
    end else if (adv_tick) begin
      pre_cnt <= '0;
      acc     <= acc + step;
    end else begin
      pre_cnt <= pre_cnt + DIV_W'(1);
    end
  end

  assign phase_idx = acc[ACC_W-1 -: IDX_W];

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (acc == '0) && (pre_cnt == '0)); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !adv_tick) |=> $stable(acc)); // R2

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(div_sel)) |-> (pre_cnt <= div_sel)); // R2

  AST_DIV0_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div_sel == '0 && step != '0) |=> !$stable(acc)); // R3

  AST_LATE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre_cnt > div_sel) |=> (pre_cnt == '0)); // R11

endmodule

// File: rtl/cwg_cos_rom.sv
module cwg_cos_rom #(
  parameter int SAMP_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [SAMP_W-1:0] sample
);

  localparam int QN  = 2 ** (IDX_W - 2);
  localparam int QW  = IDX_W - 1;
  localparam int MID = 2 ** (SAMP_W - 1);
  localparam int AMP = MID - 1;

  logic [SAMP_W-2:0] qtab [QN+1];

  for (genvar j = 0; j <= QN; j++) begin : g_quarter
    localparam int QV = cwg_pkg::quarter_amp(j, QN, AMP);
    assign qtab[j] = QV[SAMP_W-2:0];
  end

  logic [1:0]        quad;
  logic [IDX_W-3:0]  rem;
  logic [QW-1:0]     tidx;
  logic              below_mid;
  logic [SAMP_W-2:0] mag;

  always_comb begin
    quad      = idx[IDX_W-1 -: 2];
    rem       = idx[IDX_W-3:0];
    // odd quadrants walk the table backwards
    tidx      = quad[0] ? (QW'(QN) - QW'(rem)) : QW'(rem);
    // second and third quadrants lie below mid-scale
    below_mid = quad[0] ^ quad[1];
    mag       = qtab[tidx];
    sample    = below_mid ? (SAMP_W'(MID) - SAMP_W'(mag))
                          : (SAMP_W'(MID) + SAMP_W'(mag));
  end

endmodule

// File: rtl/cwg_chan.sv
module cwg_chan
  import cwg_pkg::*;
#(
  parameter int SAMP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SAMP_W-1:0]  sample,
  input  logic               src_gen,
  input  logic [SCALE_W-1:0] scale_code,
  input  logic [SAMP_W-1:0]  offset,
  input  logic [INV_W-1:0]   invert_code,
  input  logic [SAMP_W-1:0]  static_val,
  output logic [SAMP_W-1:0]  out_q
);

  localparam int MID     = 2 ** (SAMP_W - 1);
  localparam int BAND_LO = MID - MID / 8;
  localparam int BAND_HI = MID + MID / 8 - 1;

  typedef logic [SAMP_W-1:0] smp_t;

  function automatic smp_t shift_about_mid(smp_t x, logic [SCALE_W-1:0] code);
    logic signed [SAMP_W-1:0] centred;
    centred = signed'(x ^ smp_t'(MID));
    centred = centred >>> code;
    return smp_t'(centred) ^ smp_t'(MID);
  endfunction

  function automatic smp_t invert_mask(inv_mode_e m);
    case (m)
      INV_NONE: return '0;
      INV_ALL:  return '1;
      INV_MSB:  return smp_t'(MID);
      default:  return smp_t'(MID - 1);
    endcase
  endfunction

  smp_t scaled_w;
  smp_t mixed_w;
  smp_t gen_w;

  assign scaled_w = shift_about_mid(sample, scale_code);
  assign mixed_w  = scaled_w + offset;
  assign gen_w    = mixed_w ^ invert_mask(inv_mode_e'(invert_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= src_gen ? gen_w : static_val;
  end

  AST_STATIC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !src_gen |=> (out_q == $past(static_val))); // R9

  AST_EIGHTH_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (src_gen && scale_code == SCALE_W'(3) && offset == '0 && invert_code == INV_W'(0))
    |=> (out_q >= smp_t'(BAND_LO)) && (out_q <= smp_t'(BAND_HI))); // R6

  AST_MSB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (src_gen && scale_code == '0 && offset == '0 && invert_code == INV_W'(2))
    |=> (out_q[SAMP_W-1] != $past(sample[SAMP_W-1]))
        && (out_q[SAMP_W-2:0] == $past(sample[SAMP_W-2:0]))); // R8

endmodule

// File: rtl/cwg_dual.sv
module cwg_dual
  import cwg_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ACC_W  = 16,
  parameter int DIV_W  = 3,
  parameter int SAMP_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tone_en,
  input  logic [DIV_W-1:0]        div_sel,
  input  logic [ACC_W-1:0]        freq_step,
  input  logic [NCH-1:0]          ch_src_gen,
  input  logic [NCH*SCALE_W-1:0]  ch_scale,
  input  logic [NCH*SAMP_W-1:0]   ch_offset,
  input  logic [NCH*INV_W-1:0]    ch_invert,
  input  logic [NCH*SAMP_W-1:0]   ch_static,
  output logic [NCH*SAMP_W-1:0]   ch_out
);

  localparam int MID = 2 ** (SAMP_W - 1);

  logic [IDX_W-1:0]  phase_idx;
  logic [SAMP_W-1:0] cos_sample;

  cwg_phase #(.ACC_W(ACC_W), .DIV_W(DIV_W), .IDX_W(IDX_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (tone_en),
    .div_sel   (div_sel),
    .step      (freq_step),
    .phase_idx (phase_idx)
  );

  cwg_cos_rom #(.SAMP_W(SAMP_W), .IDX_W(IDX_W)) u_rom (
    .idx    (phase_idx),
    .sample (cos_sample)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    cwg_chan #(.SAMP_W(SAMP_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample      (cos_sample),
      .src_gen     (ch_src_gen[c]),
      .scale_code  (ch_scale[c*SCALE_W +: SCALE_W]),
      .offset      (ch_offset[c*SAMP_W +: SAMP_W]),
      .invert_code (ch_invert[c*INV_W +: INV_W]),
      .static_val  (ch_static[c*SAMP_W +: SAMP_W]),
      .out_q       (ch_out[c*SAMP_W +: SAMP_W])
    );
  end

  AST_REST_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_en |=> (cos_sample == SAMP_W'(2 * MID - 1))); // R5

endmodule

// File: tb/cwg_dual_test.sv
module cwg_dual_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tone_en;
  logic [2:0]  div_sel;
  logic [15:0] freq_step;
  logic [1:0]  ch_src_gen;
  logic [3:0]  ch_scale;
  logic [15:0] ch_offset;
  logic [3:0]  ch_invert;
  logic [15:0] ch_static;
  logic [15:0] ch_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cwg_dual uut (
    .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .div_sel(div_sel),
    .freq_step(freq_step), .ch_src_gen(ch_src_gen), .ch_scale(ch_scale),
    .ch_offset(ch_offset), .ch_invert(ch_invert), .ch_static(ch_static),
    .ch_out(ch_out)
  );

  typedef struct packed {
    logic [2:0]  div;
    logic [15:0] step;
    logic [1:0]  src;
    logic [3:0]  sc;
    logic [15:0] off;
    logic [3:0]  inv;
    logic [15:0] stat;
    logic [7:0]  ncyc;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 16'h0800, 2'b11, 4'b0100, 16'h0000, 4'b1000, 16'h0000, 8'd24},
    '{3'd2, 16'h1234, 2'b11, 4'b1110, 16'hC040, 4'b1101, 16'h0000, 8'd24},
    '{3'd7, 16'h3000, 2'b01, 4'b0000, 16'h0090, 4'b0000, 16'hA500, 8'd24},
    '{3'd0, 16'hFFFF, 2'b11, 4'b0001, 16'h0010, 4'b0111, 16'h0000, 8'd20},
    '{3'd1, 16'h8000, 2'b10, 4'b1000, 16'h2000, 4'b1000, 16'h003C, 8'd16},
    '{3'd4, 16'h0001, 2'b11, 4'b0111, 16'hFF01, 4'b1001, 16'h0000, 8'd12}
  };

  function automatic int ref_cos(int p);
    real ang;
    ang = 2.0 * 3.14159265358979 * real'(p) / 256.0;
    return $rtoi($floor(128.0 + 127.0 * $cos(ang) + 0.5));
  endfunction

  function automatic int ref_out(int p, int sc, int off, int inv);
    int v;
    int y;
    v = ref_cos(p) - 128;
    y = 128 + $rtoi($floor(real'(v) / real'(1 << sc)));
    y = (y + off) % 256;
    case (inv)
      1: y = 255 - y;
      2: y = (y + 128) % 256;
      3: y = (y & 128) | (127 - (y & 127));
      default: ;
    endcase
    return y;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chan_expect(int ch, int p, string tag);
    int e;
    if (ch_src_gen[ch])
      e = ref_out(p, int'(ch_scale[ch*2 +: 2]), int'(ch_offset[ch*8 +: 8]),
                  int'(ch_invert[ch*2 +: 2]));
    else
      e = int'(ch_static[ch*8 +: 8]);
    check(tag, int'(ch_out[ch*8 +: 8]), e, $sformatf("channel %0d phase %0d", ch, p));
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    rst_n = 1'b0; tone_en = 1'b0; div_sel = '0; freq_step = '0;
    ch_src_gen = '0; ch_scale = '0; ch_offset = '0; ch_invert = '0;
    ch_static = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    check("R1", int'(ch_out), 0, "output during reset");
    rst_n = 1'b1;

    // table walk: R2 R3 R5 R6 R7 R8 R10 R12 on generated channels, R9 on static ones
    for (int vi = 0; vi < 6; vi++) begin
      @(negedge clk);
      tone_en    = 1'b0;
      div_sel    = VECS[vi].div;
      freq_step  = VECS[vi].step;
      ch_src_gen = VECS[vi].src;
      ch_scale   = VECS[vi].sc;
      ch_offset  = VECS[vi].off;
      ch_invert  = VECS[vi].inv;
      ch_static  = VECS[vi].stat;
      @(negedge clk);
      tone_en = 1'b1;
      for (int k = 1; k <= int'(VECS[vi].ncyc); k++) begin
        int accv;
        @(negedge clk);
        accv = (((k - 1) / (int'(VECS[vi].div) + 1)) * int'(VECS[vi].step)) & 16'hFFFF;
        for (int ch = 0; ch < 2; ch++)
          chan_expect(ch, accv >> 8, ch_src_gen[ch] ? "R2 R3 R5 R6 R7 R8 R10 R12" : "R9");
      end
    end

    // R4: disabling clears the phase; restart begins at phase 0
    @(negedge clk);
    tone_en = 1'b0; div_sel = 3'd0; freq_step = 16'h0800;
    ch_src_gen = 2'b11; ch_scale = '0; ch_offset = '0; ch_invert = '0;
    @(negedge clk); tone_en = 1'b1;
    repeat (10) @(negedge clk);
    tone_en = 1'b0;
    @(negedge clk); tone_en = 1'b1;
    @(negedge clk);
    check("R4", int'(ch_out[7:0]), 255, "first sample after restart");
    @(negedge clk);
    check("R4", int'(ch_out[7:0]), ref_out(8, 0, 0, 0), "second sample after restart");

    // R11: lowering the divider below the current count
    tone_en = 1'b0; div_sel = 3'd7; freq_step = 16'h4000;
    @(negedge clk); tone_en = 1'b1;
    repeat (5) @(negedge clk);
    check("R11", int'(ch_out[7:0]), 255, "no advance yet at divide by 8");
    div_sel = 3'd2;
    @(negedge clk);
    check("R11", int'(ch_out[7:0]), 255, "latency before lowered divider shows");
    @(negedge clk);
    check("R11", int'(ch_out[7:0]), 128, "advance right after lowering divider");
    @(negedge clk);
    check("R11", int'(ch_out[7:0]), 128, "hold under new period");
    @(negedge clk);
    check("R11", int'(ch_out[7:0]), 128, "hold under new period");
    @(negedge clk);
    check("R11", int'(ch_out[7:0]), 1, "next advance after three cycles");
    check("R12", int'(ch_out[15:8]), 1, "second channel on shared phase");

    // R9: static byte independent of the generator
    ch_src_gen = 2'b00; ch_static = 16'h5AC3; tone_en = 1'b0;
    @(negedge clk);
    check("R9", int'(ch_out), 16'h5AC3, "static with generator stopped");
    tone_en = 1'b1; ch_scale = 4'b1111; ch_invert = 4'b0101;
    repeat (3) @(negedge clk);
    check("R9", int'(ch_out), 16'h5AC3, "static with generator running");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule